// File: doc/BRIEF.md
# Approximate Unsigned Multiplier with Error Recovery

This block multiplies two unsigned operands and returns a full-width product that is close to, but not always equal to, the exact product. It is purely combinational. The aim is a short critical path. Partial products come from an AND array. They are summed pairwise in a tree of approximate adders, in which a carry moves at most one bit position. Each approximate adder also reports where its carries arose. Those positions are merged into one carry vector. A recovery stage then folds the upper part of that vector back into the result before a single exact adder forms the product.

Three things are fixed at elaboration. The recovery style is either OR-folding or folding with another limited-carry adder. The number of upper carry-vector bits used for recovery is a parameter. A truncation parameter discards all partial-product bits below a chosen column. The default is an 8x8 multiplier with OR recovery over four bits and no truncation. The 16x16 variant drops the lower sixteen columns.

Top module: `approx_mult`

## Requirements
- R1: Operands are unsigned and OP_W bits wide (default 8); the product `prod` is 2*OP_W bits and is formed without any register, so it follows the operands combinationally.
- R2: Each approximate adder computes bit i of its sum as (a_i XOR b_i) OR (a_{i-1} AND b_{i-1}), with bit 0 as a_0 XOR b_0, so a carry never travels past the adjacent bit; when only one partial-product row is non-zero (op_b a power of two, no truncation) the product is exact.
- R3: Row k of the AND array is op_a shifted left by k when op_b[k] is 1, else zero; each tree level adds rows 2j and 2j+1 into row j, halving the row count until two rows (X from index 0, Y from index 1) remain; e.g. 3*3 gives 5 and 15*3 gives 29.
- R4: Every tree adder contributes (a AND b) shifted left by one to a carry vector by OR; recovery uses only bits 2*OP_W-1 down to 2*OP_W-REC_BITS of that vector (default bits 15..12), and when the whole vector is zero the product is exact.
- R5: In OR recovery mode (REC_MODE = REC_OR, encoding 0) the product is X + (Y OR W), where W is the recovery window of R4 placed at its bit positions, with the sum taken modulo 2^(2*OP_W).
- R6: In adder recovery mode (REC_MODE = REC_ADD, encoding 1) the product is X + A(Y, W), where A is the limited-carry adder of R2, with the sum taken modulo 2^(2*OP_W).
- R7: With TRUNC_COLS = c, every partial-product bit in a column below c is discarded before the tree; in the 16x16 variant c is 16, so 0x00FF*0x0001 gives 0 and 0x0100*0x0100 gives 0x10000.
- R8: A zero on either operand gives a zero product in every mode and variant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | OP_W | Multiplicand, unsigned |
| op_b | input | OP_W | Multiplier, unsigned |
| prod | output | 2*OP_W | Approximate product |

## Verification
Every result of this block is due in the same clock cycle as its operands, because no register lies between the ports. The bench therefore changes operands just after a rising edge and reads the product at the following falling edge, half a period later, when the logic has settled. All 65536 operand pairs of the 8x8 build are compared in both recovery modes against a bench model written from R2 to R6. The 16x16 truncated build gets hand-computed and pseudo-random pairs. The mean error distance of each mode against the exact product is reported.

// File: rtl/amul_pkg.sv
package amul_pkg;

  // recovery style selected at elaboration
  typedef enum logic {
    REC_OR  = 1'b0,
    REC_ADD = 1'b1
  } rec_mode_e;

  // first node index of a tree level in the flat node array
  function automatic int lvl_off(input int op_w, input int lvl);
    return 2 * op_w - ((2 * op_w) >> lvl);
  endfunction

endpackage

// File: rtl/amul_approx_add.sv
module amul_approx_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] err_o
);

  logic [W-1:0] gen;
  logic [W-1:0] prop;

  assign gen   = a_i & b_i;
  assign prop  = a_i ^ b_i;
  // a carry reaches only the neighbouring bit
  assign sum_o = prop | {gen[W-2:0], 1'b0};
  assign err_o = gen;

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      // R2
      exact_when_no_carry_chk: assert ((gen != '0) ||
          ({1'b0, sum_o} == ({1'b0, a_i} + {1'b0, b_i})))
        else $error("approximate adder differs from exact sum with no carry");
    end
  end

endmodule

// File: rtl/amul_pp_gen.sv
module amul_pp_gen #(
  parameter int OP_W       = 8,
  parameter int TRUNC_COLS = 0
) (
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  output logic [2*OP_W-1:0] rows_o [OP_W]
);

  localparam int PW = 2 * OP_W;
  localparam logic [PW-1:0] KEEP = {PW{1'b1}} << TRUNC_COLS;

  for (genvar k = 0; k < OP_W; k++) begin : g_row
    assign rows_o[k] = (PW'(a_i & {OP_W{b_i[k]}}) << k) & KEEP;
  end

  always_comb begin
    if (TRUNC_COLS == 0 && !$isunknown({a_i, b_i})) begin
      for (int k = 0; k < OP_W; k++) begin
        // R3
        row_weight_chk: assert ($countones(rows_o[k]) ==
            (b_i[k] ? $countones(a_i) : 0))
          else $error("partial-product row %0d has wrong bit count", k);
      end
    end
  end

endmodule

// File: rtl/amul_reduce_tree.sv
module amul_reduce_tree #(
  parameter int OP_W = 8,
  parameter int PW   = 2 * OP_W
) (
  input  logic [PW-1:0] rows_i [OP_W],
  output logic [PW-1:0] x_o,
  output logic [PW-1:0] y_o,
  output logic [PW:0]   carry_o
);

  localparam int LEVELS = $clog2(OP_W) - 1;
  localparam int NODES  = 2 * OP_W - 2;
  localparam int ADDERS = OP_W - 2;

  logic [PW-1:0] node [NODES];
  logic [PW-1:0] err  [ADDERS];

  for (genvar k = 0; k < OP_W; k++) begin : g_leaf
    assign node[k] = rows_i[k];
  end

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int IN_OFF  = amul_pkg::lvl_off(OP_W, l);
    localparam int OUT_OFF = amul_pkg::lvl_off(OP_W, l + 1);
    for (genvar j = 0; j < (OP_W >> (l + 1)); j++) begin : g_pair
      amul_approx_add #(.W(PW)) u_add (
        .a_i   (node[IN_OFF + 2*j]),
        .b_i   (node[IN_OFF + 2*j + 1]),
        .sum_o (node[OUT_OFF + j]),
        .err_o (err[OUT_OFF + j - OP_W])
      );
    end
  end

  assign x_o = node[NODES-2];
  assign y_o = node[NODES-1];

  always_comb begin
    carry_o = '0;
    for (int e = 0; e < ADDERS; e++) begin
      carry_o = carry_o | {err[e], 1'b0};
    end
  end

endmodule

// File: rtl/amul_recover.sv
module amul_recover #(
  parameter int                  PW       = 16,
  parameter int                  REC_BITS = 4,
  parameter amul_pkg::rec_mode_e REC_MODE = amul_pkg::REC_OR
) (
  input  logic [PW-1:0]       y_i,
  input  logic [REC_BITS-1:0] win_i,
  output logic [PW-1:0]       y_o
);

  logic [PW-1:0] win_full;

  assign win_full = PW'(win_i) << (PW - REC_BITS);

  if (REC_MODE == amul_pkg::REC_ADD) begin : g_fold_add
    logic [PW-1:0] fold_err;

    amul_approx_add #(.W(PW)) u_fold (
      .a_i   (y_i),
      .b_i   (win_full),
      .sum_o (y_o),
      .err_o (fold_err)
    );

    always_comb begin
      if (!$isunknown({y_i, win_i})) begin
        // R6
        fold_add_disjoint_chk: assert ((fold_err != '0) || (y_o == (y_i | win_full)))
          else $error("adder recovery differs from merge on disjoint bits");
      end
    end
  end else begin : g_fold_or
    assign y_o = y_i | win_full;

    always_comb begin
      if (!$isunknown({y_i, win_i})) begin
        // R5
        or_fold_idle_chk: assert ((win_i != '0) || (y_o == y_i))
          else $error("OR recovery changed row with empty window");
      end
    end
  end

endmodule

// File: rtl/approx_mult.sv
module approx_mult #(
  parameter int                  OP_W       = 8,
  parameter int                  REC_BITS   = 4,
  parameter amul_pkg::rec_mode_e REC_MODE   = amul_pkg::REC_OR,
  parameter int                  TRUNC_COLS = 0
) (
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  output logic [2*OP_W-1:0] prod
);

  localparam int PW = 2 * OP_W;

  logic [PW-1:0] pp_rows [OP_W];
  logic [PW-1:0] row_x;
  logic [PW-1:0] row_y;
  logic [PW-1:0] row_y_fix;
  logic [PW:0]   carry_vec;

  amul_pp_gen #(.OP_W(OP_W), .TRUNC_COLS(TRUNC_COLS)) u_pp (
    .a_i    (op_a),
    .b_i    (op_b),
    .rows_o (pp_rows)
  );

  amul_reduce_tree #(.OP_W(OP_W), .PW(PW)) u_tree (
    .rows_i  (pp_rows),
    .x_o     (row_x),
    .y_o     (row_y),
    .carry_o (carry_vec)
  );

  amul_recover #(.PW(PW), .REC_BITS(REC_BITS), .REC_MODE(REC_MODE)) u_rec (
    .y_i   (row_y),
    .win_i (carry_vec[PW-1 -: REC_BITS]),
    .y_o   (row_y_fix)
  );

  // single exact adder closes the product
  assign prod = row_x + row_y_fix;

  always_comb begin
    if (!$isunknown({op_a, op_b})) begin
      // R8
      zero_in_zero_out_chk: assert (!((op_a == '0) || (op_b == '0)) || (prod == '0))
        else $error("zero operand gave non-zero product");
      if (TRUNC_COLS == 0) begin
        // R4
        no_carry_exact_chk: assert ((carry_vec != '0) ||
            (prod == ({{OP_W{1'b0}}, op_a} * {{OP_W{1'b0}}, op_b})))
          else $error("no carry recorded but product is inexact");
        // R2
        single_row_exact_chk: assert (!$onehot(op_b) ||
            (prod == ({{OP_W{1'b0}}, op_a} * {{OP_W{1'b0}}, op_b})))
          else $error("single-row product is inexact");
      end
    end
  end

endmodule

// File: tb/approx_mult_test.sv
module approx_mult_test;

  logic clk;
  logic rst_n;
  logic [7:0]  a8, b8;
  logic [15:0] p_or, p_add;
  logic [15:0] a16, b16;
  logic [31:0] p16;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  approx_mult #(.OP_W(8), .REC_BITS(4), .REC_MODE(amul_pkg::REC_OR), .TRUNC_COLS(0)) uut (
    .op_a(a8), .op_b(b8), .prod(p_or));

  approx_mult #(.OP_W(8), .REC_BITS(4), .REC_MODE(amul_pkg::REC_ADD), .TRUNC_COLS(0)) uut_add (
    .op_a(a8), .op_b(b8), .prod(p_add));

  approx_mult #(.OP_W(16), .REC_BITS(4), .REC_MODE(amul_pkg::REC_OR), .TRUNC_COLS(16)) uut_t16 (
    .op_a(a16), .op_b(b16), .prod(p16));

  // behavioural model written from R2..R7
  function automatic logic [31:0] model(input logic [15:0] a, input logic [15:0] b,
                                        input int n, input int rb, input bit add_mode,
                                        input int tc);
    logic [63:0] r [16];
    logic [63:0] pm, g, carry, win, y2, p;
    int cnt;
    pm = (64'd1 << (2 * n)) - 64'd1;
    for (int k = 0; k < 16; k++)
      r[k] = (k < n && b[k]) ? ((64'(a) << k) & pm & ~((64'd1 << tc) - 64'd1)) : 64'd0;
    carry = 64'd0;
    cnt = n;
    while (cnt > 2) begin
      for (int j = 0; j < cnt / 2; j++) begin
        g = r[2*j] & r[2*j+1];
        carry = carry | (g << 1);
        r[j] = ((r[2*j] ^ r[2*j+1]) | (g << 1)) & pm;
      end
      cnt = cnt / 2;
    end
    win = carry & pm & ~((64'd1 << (2 * n - rb)) - 64'd1);
    y2 = add_mode ? (((r[1] ^ win) | ((r[1] & win) << 1)) & pm) : (r[1] | win);
    p = (r[0] + y2) & pm;
    return p[31:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic drive8(input logic [7:0] a, input logic [7:0] b);
    @(posedge clk);
    #1;
    a8 = a;
    b8 = b;
    @(negedge clk);
  endtask

  task automatic drive16(input logic [15:0] a, input logic [15:0] b);
    @(posedge clk);
    #1;
    a16 = a;
    b16 = b;
    @(negedge clk);
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    chk("R8 reset-state OR", 32'(p_or), 32'd0);
    chk("R8 reset-state ADD", 32'(p_add), 32'd0);
    chk("R8 reset-state 16x16", p16, 32'd0);
  endtask

  task automatic t_zero;
    drive8(8'd0, 8'hFF);
    chk("R8 zero a OR", 32'(p_or), 32'd0);
    chk("R8 zero a ADD", 32'(p_add), 32'd0);
    drive8(8'hB7, 8'd0);
    chk("R8 zero b OR", 32'(p_or), 32'd0);
    chk("R8 zero b ADD", 32'(p_add), 32'd0);
    drive16(16'hFFFF, 16'd0);
    chk("R8 zero b 16x16", p16, 32'd0);
  endtask

  task automatic t_single_row;
    for (int k = 0; k < 8; k++) begin
      drive8(8'hFF, 8'(1 << k));
      chk("R2 one-row exact OR", 32'(p_or), 32'hFF << k);
      chk("R2 one-row exact ADD", 32'(p_add), 32'hFF << k);
    end
  endtask

  task automatic t_hand_values;
    drive8(8'd3, 8'd3);
    chk("R3 3*3 OR", 32'(p_or), 32'd5);
    chk("R3 3*3 ADD", 32'(p_add), 32'd5);
    drive8(8'd15, 8'd3);
    chk("R3 15*3 OR", 32'(p_or), 32'd29);
    chk("R3 15*3 ADD", 32'(p_add), 32'd29);
  endtask

  task automatic t_exhaustive;
    longint sum_or = 0;
    longint sum_add = 0;
    longint ex;
    int diff_modes = 0;
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        drive8(8'(a), 8'(b));
        chk("R1 R4 R5 exhaustive OR", 32'(p_or), model(16'(a), 16'(b), 8, 4, 1'b0, 0));
        chk("R1 R4 R6 exhaustive ADD", 32'(p_add), model(16'(a), 16'(b), 8, 4, 1'b1, 0));
        ex = longint'(a * b);
        sum_or  += (longint'(p_or) > ex) ? longint'(p_or) - ex : ex - longint'(p_or);
        sum_add += (longint'(p_add) > ex) ? longint'(p_add) - ex : ex - longint'(p_add);
        if (p_or != p_add) diff_modes++;
      end
    end
    $display("mean error distance: OR recovery %f, adder recovery %f, pairs differing %0d",
             real'(sum_or) / 65536.0, real'(sum_add) / 65536.0, diff_modes);
  endtask

  task automatic t_trunc16;
    logic [15:0] sa = 16'hACE1;
    logic [15:0] sb = 16'h1D2B;
    drive16(16'h00FF, 16'h0001);
    chk("R7 low columns dropped", p16, 32'd0);
    drive16(16'h0100, 16'h0100);
    chk("R7 column 16 kept", p16, 32'h0001_0000);
    drive16(16'hFFFF, 16'hFFFF);
    chk("R7 all ones 16x16", p16, model(16'hFFFF, 16'hFFFF, 16, 4, 1'b0, 16));
    for (int i = 0; i < 200; i++) begin
      sa = {sa[14:0], sa[15] ^ sa[13] ^ sa[12] ^ sa[10]};
      sb = {sb[14:0], sb[15] ^ sb[13] ^ sb[12] ^ sb[10]};
      drive16(sa, sb);
      chk("R7 R5 random 16x16", p16, model(sa, sb, 16, 4, 1'b0, 16));
    end
  endtask

  initial begin
    rst_n = 1'b0;
    a8 = '0;
    b8 = '0;
    a16 = '0;
    b16 = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset_state();
    t_zero();
    t_single_row();
    t_hand_values();
    t_trunc16();
    t_exhaustive();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule